// File: doc/BRIEF.md
# Mailbox Command Requester with Tick-Based Timeout

This block issues one command at a time to a management controller that sits behind a small register mailbox. On an accepted start it optionally stores a 32-bit argument word into the mailbox argument register, then stores the command number into the message register. After that it watches the controller's response field. The field is sampled once per microsecond tick, and the tick comes from an internal prescaler.

Polling stops at the first nonzero sample, or when the configured number of ticks has gone by. The block then reads the response one last time and reports that value. The final code is classified as follows:

- 0xFE and 0xFF are errors.
- Any other value is success, and that includes 0 after a timeout.

The start, busy and done pins are plain control pins. There is no data stream, so there is no valid/ready pair and no back-pressure. A caller watches busy and done. A start pulse is accepted only while busy is low.

Top module: `mbx_msg_requester`

## Requirements
- R1: When the argument-valid input is high at an accepted start, the argument word appears on the mailbox argument port with its write strobe high for exactly one cycle, and the message write strobe follows in the very next cycle.
- R2: When the argument-valid input is low at an accepted start, the argument write strobe stays low for the whole command.
- R3: Each accepted command produces exactly one message write, and the written value is the low MSG_W bits (16 by default) of the command number.
- R4: The response field is sampled only at ticks, which come every CLK_DIV cycles counted from the message write. A nonzero sample at tick k ends polling, and done rises k*CLK_DIV+2 cycles after the message write cycle.
- R5: With no nonzero sample, polling ends after exactly the configured number of ticks T, and done rises T*CLK_DIV+3 cycles after the message write cycle. T=0 ends at once with a latency of 3.
- R6: The response output shows the value read in the final read that follows the end of polling.
- R7: The error output is high exactly when that final code is 0xFE or 0xFF. The codes 1, 0 (after a timeout) and any other value give error low.
- R8: Done is a one-cycle pulse, and busy is low while done is high. The response and error outputs keep their values after done until the next accepted start.
- R9: A start pulse that arrives while busy is high causes no mailbox write and does not change the result of the command in flight.
- R10: After reset, busy, done, error, the response output and both write strobes are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| cmd_id_i | input | ID_W (32) | Command number |
| arg_valid_i | input | 1 | Argument word is to be written first |
| arg_i | input | ARG_W (32) | Argument word |
| tmo_ticks_i | input | TMO_W (16) | Timeout length in microsecond ticks |
| busy_o | output | 1 | Command in flight |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Final code was an error code |
| resp_o | output | RESP_W (8) | Final response code |
| mbx_arg_we_o | output | 1 | Argument register write strobe |
| mbx_arg_o | output | ARG_W (32) | Argument register write data |
| mbx_msg_we_o | output | 1 | Message register write strobe |
| mbx_msg_o | output | MSG_W (16) | Message register write data |
| mbx_resp_i | input | RESP_W (8) | Response field read from the controller |

## Verification
The hardest case to reach is a response that becomes nonzero on the exact cycle of a tick, or one cycle before or after it. That case decides whether the block stops at tick k or tick k+1, and the difference shows up directly in the done latency. The bench draws the responder delay uniformly from 1 to T*CLK_DIV, so exact multiples of the divisor and their neighbours come up often. Every done latency is compared against a value computed from the delay. A second hard case is a start pulse injected in the middle of polling, and directed runs place one there.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARG   = 3'd1,
    ST_MSG   = 3'd2,
    ST_POLL  = 3'd3,
    ST_FINAL = 3'd4
  } req_state_e;

  localparam int unsigned RESP_W_DEF = 8;
  localparam logic [RESP_W_DEF-1:0] CODE_OK      = 8'h01;
  localparam logic [RESP_W_DEF-1:0] CODE_REJECT  = 8'hFE;
  localparam logic [RESP_W_DEF-1:0] CODE_FAILURE = 8'hFF;

endpackage

// File: rtl/mbx_us_tick.sv
module mbx_us_tick #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  generate
    if (CLK_DIV > 1) begin : g_spacing
      // R4: ticks never come on back-to-back cycles
      assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/mbx_poll_count.sv
module mbx_poll_count #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  assign expired_o = (cnt_q == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && !expired_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: the tick count never runs past the configured limit
  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |-> (cnt_q <= limit_i));

endmodule

// File: rtl/mbx_resp_eval.sv
module mbx_resp_eval #(
  parameter int unsigned RESP_W = 8
) (
  input  logic [RESP_W-1:0] code_i,
  output logic              answered_o,
  output logic              is_err_o
);
  localparam logic [RESP_W-1:0] C_REJ  = RESP_W'(8'hFE);
  localparam logic [RESP_W-1:0] C_FAIL = RESP_W'(8'hFF);

  always_comb begin
    answered_o = (code_i != '0);
    is_err_o   = (code_i == C_REJ) || (code_i == C_FAIL);
  end

endmodule

// File: rtl/mbx_msg_requester.sv
module mbx_msg_requester
  import mbx_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned ID_W    = 32,
  parameter int unsigned MSG_W   = 16,
  parameter int unsigned ARG_W   = 32,
  parameter int unsigned TMO_W   = 16,
  parameter int unsigned RESP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic              arg_valid_i,
  input  logic [ARG_W-1:0]  arg_i,
  input  logic [TMO_W-1:0]  tmo_ticks_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [RESP_W-1:0] resp_o,
  output logic              mbx_arg_we_o,
  output logic [ARG_W-1:0]  mbx_arg_o,
  output logic              mbx_msg_we_o,
  output logic [MSG_W-1:0]  mbx_msg_o,
  input  logic [RESP_W-1:0] mbx_resp_i
);
  localparam int unsigned KEEP_W = (MSG_W < ID_W) ? MSG_W : ID_W;

  req_state_e        state_q, state_d;
  logic [KEEP_W-1:0] msg_q;
  logic [ARG_W-1:0]  arg_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              done_q, err_q;
  logic [RESP_W-1:0] resp_q;

  logic tick, expired, answered, is_err, accept;

  assign accept = start_i && (state_q == ST_IDLE);

  mbx_us_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (state_q != ST_POLL),
    .tick_o (tick)
  );

  mbx_poll_count #(.TMO_W(TMO_W)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (state_q != ST_POLL),
    .inc_i     (tick),
    .limit_i   (tmo_q),
    .expired_o (expired)
  );

  mbx_resp_eval #(.RESP_W(RESP_W)) u_eval (
    .code_i     (mbx_resp_i),
    .answered_o (answered),
    .is_err_o   (is_err)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = arg_valid_i ? ST_ARG : ST_MSG;
      ST_ARG:   state_d = ST_MSG;
      ST_MSG:   state_d = ST_POLL;
      ST_POLL: begin
        if (expired)              state_d = ST_FINAL;
        else if (tick && answered) state_d = ST_FINAL;
      end
      ST_FINAL: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      msg_q   <= '0;
      arg_q   <= '0;
      tmo_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      resp_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FINAL);
      if (accept) begin
        msg_q  <= cmd_id_i[KEEP_W-1:0];
        arg_q  <= arg_i;
        tmo_q  <= tmo_ticks_i;
        err_q  <= 1'b0;
        resp_q <= '0;
      end
      if (state_q == ST_FINAL) begin
        resp_q <= mbx_resp_i;
        err_q  <= is_err;
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign resp_o       = resp_q;
  assign mbx_arg_we_o = (state_q == ST_ARG);
  assign mbx_arg_o    = arg_q;
  assign mbx_msg_we_o = (state_q == ST_MSG);
  assign mbx_msg_o    = MSG_W'(msg_q);

  // R1: an argument write is followed straight away by the message write
  assert_arg_then_msg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_arg_we_o |=> mbx_msg_we_o);

  // R3: one message write per command
  assert_single_msg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_msg_we_o |=> !mbx_msg_we_o);

  // R7: the error flag only ever goes with an error code
  assert_err_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (resp_o == RESP_W'(8'hFE) || resp_o == RESP_W'(8'hFF)));

  // R8: done lasts one cycle and comes with busy low
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R9: a start while busy leaves the captured command untouched
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(msg_q) && $stable(arg_q) && $stable(tmo_q)));

endmodule

// File: tb/mbx_msg_requester_tb.sv
module mbx_msg_requester_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] cmd_id_i = '0;
  logic        arg_valid_i = 1'b0;
  logic [31:0] arg_i = '0;
  logic [15:0] tmo_ticks_i = '0;
  logic        busy_o, done_o, err_o;
  logic [7:0]  resp_o;
  logic        mbx_arg_we_o, mbx_msg_we_o;
  logic [31:0] mbx_arg_o;
  logic [15:0] mbx_msg_o;
  logic [7:0]  mbx_resp_i = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mbx_msg_requester #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_id_i(cmd_id_i),
    .arg_valid_i(arg_valid_i), .arg_i(arg_i), .tmo_ticks_i(tmo_ticks_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .resp_o(resp_o),
    .mbx_arg_we_o(mbx_arg_we_o), .mbx_arg_o(mbx_arg_o),
    .mbx_msg_we_o(mbx_msg_we_o), .mbx_msg_o(mbx_msg_o), .mbx_resp_i(mbx_resp_i)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(input logic [7:0] c);
    return (c == 8'hFE) || (c == 8'hFF);
  endfunction

  function automatic int exp_lat(input bit answered, input int d, input int t);
    if (answered) return ((d + DIV - 1) / DIV) * DIV + 2;
    return t * DIV + 3;
  endfunction

  task automatic run_txn(input logic [31:0] id, input bit av, input logic [31:0] arg,
                         input int t, input bit answer, input logic [7:0] code,
                         input int d, input bit inject);
    int arg_seen = 0, msg_seen = 0, lat = 0, guard = 0;
    bit arg_ok = 1'b1, prev_arg = 1'b0, order_ok = 1'b1;
    logic [15:0] msg_val = '0;
    logic [7:0] final_code;
    @(negedge clk);
    mbx_resp_i  = '0;
    cmd_id_i    = id;
    arg_valid_i = av;
    arg_i       = arg;
    tmo_ticks_i = 16'(t);
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (msg_seen == 0 && guard < 20) begin
      guard++;
      if (mbx_arg_we_o) begin
        arg_seen++;
        if (mbx_arg_o != arg) arg_ok = 1'b0;
      end
      if (mbx_msg_we_o) begin
        msg_seen++;
        msg_val = mbx_msg_o;
        if (av && !prev_arg) order_ok = 1'b0;
      end
      prev_arg = mbx_arg_we_o;
      if (msg_seen == 0) @(negedge clk);
    end
    if (av) begin
      chk(arg_seen == 1 && arg_ok, "R1 arg write", arg_seen, 1);
      chk(order_ok, "R1 arg before msg", order_ok, 1);
    end else begin
      chk(arg_seen == 0, "R2 no arg write", arg_seen, 0);
    end
    chk(msg_val == id[15:0], "R3 msg value", msg_val, id[15:0]);
    while (!done_o && lat < 2000) begin
      @(negedge clk);
      lat++;
      if (mbx_msg_we_o) msg_seen++;
      if (mbx_arg_we_o) arg_seen++;
      if (done_o) break;
      if (answer && lat == d) mbx_resp_i = code;
      if (inject && lat == 2) begin
        start_i = 1'b1; cmd_id_i = ~id; arg_valid_i = 1'b1; tmo_ticks_i = 16'd1;
      end
      if (inject && lat == 3) start_i = 1'b0;
    end
    final_code = answer ? code : 8'h00;
    chk(msg_seen == 1, "R3/R9 single msg write", msg_seen, 1);
    if (inject) chk(arg_seen == (av ? 1 : 0), "R9 no extra arg write", arg_seen, av ? 1 : 0);
    if (answer && code != 8'h00)
      chk(lat == exp_lat(1'b1, d, t), "R4 answer latency", lat, exp_lat(1'b1, d, t));
    else
      chk(lat == exp_lat(1'b0, d, t), "R5 timeout latency", lat, exp_lat(1'b0, d, t));
    chk(resp_o == final_code, "R6 response", resp_o, final_code);
    chk(err_o == exp_err(final_code), "R7 error flag", err_o, exp_err(final_code));
    chk(!busy_o, "R8 busy low at done", busy_o, 0);
    mbx_resp_i = 8'h5A;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!done_o, "R8 done one cycle", done_o, 0);
    end
    chk(resp_o == final_code && err_o == exp_err(final_code), "R8 hold result",
        resp_o, final_code);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && resp_o == 0 && !mbx_arg_we_o && !mbx_msg_we_o,
        "R10 reset state", {busy_o, done_o, err_o, resp_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_txn(32'hABCD_1234, 1'b0, 32'h0, 5, 1'b1, 8'h01, 3, 1'b0);
    run_txn(32'h0000_00FF, 1'b1, 32'hDEAD_BEEF, 4, 1'b1, 8'hFE, 8, 1'b0);
    run_txn(32'h1111_2222, 1'b1, 32'h0123_4567, 6, 1'b1, 8'hFF, 1, 1'b0);
    run_txn(32'h7777_8888, 1'b0, 32'h0, 3, 1'b1, 8'h37, 12, 1'b0);
    run_txn(32'h5555_6666, 1'b1, 32'hCAFE_F00D, 3, 1'b0, 8'h00, 0, 1'b0);
    run_txn(32'h9999_0000, 1'b0, 32'h0, 0, 1'b0, 8'h00, 0, 1'b0);
    run_txn(32'h2468_ACE0, 1'b0, 32'h0, 5, 1'b1, 8'hFE, 9, 1'b1);
    run_txn(32'h1357_9BDF, 1'b1, 32'hFFFF_0000, 4, 1'b0, 8'h00, 0, 1'b1);
    // random mix
    for (int n = 0; n < 40; n++) begin
      int t, d, sel;
      bit ans, av;
      logic [7:0] code;
      t   = 1 + int'($urandom % 12);
      d   = 1 + int'($urandom % (t * DIV));
      ans = ($urandom % 4) != 0;
      av  = $urandom % 2;
      sel = int'($urandom % 4);
      code = (sel == 0) ? 8'h01 : (sel == 1) ? 8'hFE : (sel == 2) ? 8'hFF
             : 8'(2 + $urandom % 252);
      run_txn($urandom, av, $urandom, t, ans, code, d, t >= 2 && ($urandom % 3 == 0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule